// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is an up/down counter driven from a small synchronous register bus. It runs either as a free-running timer that steps once per clock, or as a decoder for a two-phase quadrature encoder. In the encoder modes it counts the edges of phase A, the edges of phase B, or the edges of both phases. The count direction comes from the level of the other phase, so each rotation direction always moves the count the same way.

The count runs between zero and a programmable ceiling and wraps at both ends. Each wrap raises a one-cycle update pulse. A ceiling write takes effect at once, or it waits in a shadow register until an update event. Software can force an update event, and it can load the count directly when the value lies within the active ceiling. Both phase inputs are asynchronous and pass through synchronisers before any decision is made.

Top module: `qenc_timer`

## Requirements
- R1: After reset, the count is 0, the direction is 0, the update pulse is 0, the ceiling reads all ones, and the control register (address 0) reads 0.
- R2: In mode 0 (mode register at address 1, bits 1:0), the count rises by one on every clock edge at which the run bit (control bit 0) is 1.
- R3: In mode 1, only phase A edges move the count. It goes up when the new level of A differs from the level of B, and down otherwise. Phase B edges alone leave the count unchanged.
- R4: In mode 2, only phase B edges move the count. It goes up when the new level of B equals the level of A, and down otherwise. Phase A edges alone leave the count unchanged.
- R5: In mode 3, every edge of either phase moves the count, using the rules of R3 and R4. A cycle in which both synchronised phases change together leaves the count unchanged.
- R6: While the run bit is 0, the count holds its value. Encoder edges that occur while the count is stopped are not counted later.
- R7: The direction output and read-only control bit 1 read 1 after the last step was downward, and 0 after the last step was upward.
- R8: A step up from a count at or above the active ceiling gives 0. A step down from 0 gives the active ceiling. Each wrap raises the update pulse for one cycle.
- R9: The ceiling is at address 3. When the preload bit (control bit 2) is 0, a ceiling write takes effect on the next edge. When the preload bit is 1, the write only reaches the shadow register, and a ceiling read returns the shadow register.
- R10: Writing 1 to bit 0 at address 4 copies the shadow ceiling into the active ceiling. The update pulse is high in the cycle after that write.
- R11: A count write (address 2) takes effect only when the value does not exceed the active ceiling. A larger value is ignored.
- R12: A phase change moves the count on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data, valid the cycle after a read |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| count_o | output | CNT_W (16) | Live count |
| dir_o | output | 1 | Last step direction, 1 = down |
| upd_evt_o | output | 1 | One-cycle update event pulse |

## Verification
Results fall due at different times after their stimulus, and each check is placed at that time:
- **Register writes:** effects on the count, ceiling and update pulse appear on the edge that takes the write. The bench samples them at the following falling edge.
- **Register reads:** the read data is registered and is compared one cycle after the read.
- **Phase changes:** a phase change reaches the count only on the third rising edge, because of the two synchroniser flops and the edge-detect flop. The bench therefore waits three falling edges after every phase change before its scoreboard compares. One sequence also checks that the count has not yet moved after two edges.

// File: rtl/qt_pkg.sv
package qt_pkg;
  typedef enum logic [1:0] {
    QM_TIMER = 2'd0,
    QM_XA    = 2'd1,
    QM_XB    = 2'd2,
    QM_X4    = 2'd3
  } qmode_e;

  localparam int unsigned RA_CTRL  = 0;
  localparam int unsigned RA_MODE  = 1;
  localparam int unsigned RA_COUNT = 2;
  localparam int unsigned RA_CEIL  = 3;
  localparam int unsigned RA_UPD   = 4;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_DIR  = 1;
  localparam int unsigned CB_PREL = 2;
endpackage

// File: rtl/qt_sync.sv
module qt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qt_decode.sv
module qt_decode
  import qt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   a_s,
  input  logic   b_s,
  input  qmode_e mode,
  output logic   a_edge,
  output logic   b_edge,
  output logic   step_up,
  output logic   step_dn
);
  logic a_p, b_p;
  logic up_a, up_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      a_p <= a_s;
      b_p <= b_s;
    end
  end

  assign a_edge = a_s ^ a_p;
  assign b_edge = b_s ^ b_p;
  assign up_a   = a_s ^ b_s;
  assign up_b   = ~(a_s ^ b_s);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (mode)
      QM_TIMER: step_up = 1'b1;
      QM_XA: if (a_edge) begin
        step_up = up_a;
        step_dn = ~up_a;
      end
      QM_XB: if (b_edge) begin
        step_up = up_b;
        step_dn = ~up_b;
      end
      QM_X4: begin
        if (a_edge && !b_edge) begin
          step_up = up_a;
          step_dn = ~up_a;
        end else if (b_edge && !a_edge) begin
          step_up = up_b;
          step_dn = ~up_b;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qt_core.sv
module qt_core #(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] CEIL_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ceil_wr,
  input  logic [CNT_W-1:0] ceil_wdata,
  input  logic             preload,
  input  logic             force_upd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ceil_act,
  output logic [CNT_W-1:0] ceil_sh,
  output logic             dir_q,
  output logic             upd_evt
);
  logic             wr_ok;
  logic             go_up, go_dn;
  logic             nat_evt;
  logic [CNT_W-1:0] cnt_nx;

  assign wr_ok = cnt_wr && (cnt_wdata <= ceil_act);
  assign go_up = run && step_up && !wr_ok;
  assign go_dn = run && step_dn && !wr_ok;

  always_comb begin
    cnt_nx  = cnt_q;
    nat_evt = 1'b0;
    if (wr_ok) begin
      cnt_nx = cnt_wdata;
    end else if (go_up) begin
      if (cnt_q >= ceil_act) begin
        cnt_nx  = '0;
        nat_evt = 1'b1;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end else if (go_dn) begin
      if (cnt_q == '0) begin
        cnt_nx  = ceil_act;
        nat_evt = 1'b1;
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      ceil_act <= CEIL_RST;
      ceil_sh  <= CEIL_RST;
      upd_evt  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      upd_evt <= nat_evt || force_upd;
      if (go_up)      dir_q <= 1'b0;
      else if (go_dn) dir_q <= 1'b1;
      if (ceil_wr) ceil_sh <= ceil_wdata;
      if (ceil_wr && !preload)         ceil_act <= ceil_wdata;
      else if (nat_evt || force_upd)   ceil_act <= ceil_sh;
    end
  end
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qt_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               ADDR_W    = 3,
  parameter int               SYNC_STGS = 2,
  parameter logic [CNT_W-1:0] CEIL_RST  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              phase_a,
  input  logic              phase_b,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              upd_evt_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(RA_MODE);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(RA_COUNT);
  localparam logic [ADDR_W-1:0] A_CEIL  = ADDR_W'(RA_CEIL);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'(RA_UPD);

  logic   wr_hit, rd_hit;
  logic   run_q, prel_q;
  qmode_e mode_q;
  logic   a_s, b_s;
  logic   a_edge, b_edge, step_up, step_dn;
  logic   cnt_wr, ceil_wr, force_upd;
  logic [CNT_W-1:0] ceil_act, ceil_sh;

  assign wr_hit    = bus_sel && bus_wr;
  assign rd_hit    = bus_sel && !bus_wr;
  assign cnt_wr    = wr_hit && (bus_addr == A_COUNT);
  assign ceil_wr   = wr_hit && (bus_addr == A_CEIL);
  assign force_upd = wr_hit && (bus_addr == A_UPD) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      prel_q <= 1'b0;
      mode_q <= QM_TIMER;
    end else if (wr_hit) begin
      if (bus_addr == A_CTRL) begin
        run_q  <= bus_wdata[CB_RUN];
        prel_q <= bus_wdata[CB_PREL];
      end
      if (bus_addr == A_MODE) mode_q <= qmode_e'(bus_wdata[1:0]);
    end
  end

  qt_sync #(.STAGES(SYNC_STGS)) u_sync_a (.clk(clk), .rst(rst), .d(phase_a), .q(a_s));
  qt_sync #(.STAGES(SYNC_STGS)) u_sync_b (.clk(clk), .rst(rst), .d(phase_b), .q(b_s));

  qt_decode u_dec (
    .clk(clk), .rst(rst), .a_s(a_s), .b_s(b_s), .mode(mode_q),
    .a_edge(a_edge), .b_edge(b_edge), .step_up(step_up), .step_dn(step_dn)
  );

  qt_core #(.CNT_W(CNT_W), .CEIL_RST(CEIL_RST)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .step_up(step_up), .step_dn(step_dn),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .ceil_wr(ceil_wr),
    .ceil_wdata(bus_wdata), .preload(prel_q), .force_upd(force_upd),
    .cnt_q(count_o), .ceil_act(ceil_act), .ceil_sh(ceil_sh),
    .dir_q(dir_o), .upd_evt(upd_evt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_CTRL: begin
          bus_rdata[CB_RUN]  <= run_q;
          bus_rdata[CB_DIR]  <= dir_o;
          bus_rdata[CB_PREL] <= prel_q;
        end
        A_MODE:  bus_rdata[1:0] <= mode_q;
        A_COUNT: bus_rdata <= count_o;
        A_CEIL:  bus_rdata <= ceil_sh;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/qt_chk.sv
module qt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             preload,
  input logic [1:0]       mode,
  input logic             a_edge,
  input logic             b_edge,
  input logic             step_up,
  input logic             step_dn,
  input logic             cnt_wr,
  input logic             ceil_wr,
  input logic             force_upd,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] ceil_act,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             upd_evt_o
);
  AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count_o)); // R6

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run && step_up && !cnt_wr && count_o >= ceil_act) |=> (count_o == '0 && upd_evt_o)); // R8

  AST_DOWN_SETS_DIR: assert property (@(posedge clk) disable iff (rst)
    (run && step_dn && !cnt_wr) |=> dir_o); // R7

  AST_X4_BOTH_INVALID: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && a_edge && b_edge) |-> !(step_up || step_dn)); // R5

  AST_XA_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && !a_edge) |-> !(step_up || step_dn)); // R3

  AST_XB_NEEDS_B: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !b_edge) |-> !(step_up || step_dn)); // R4

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (preload && ceil_wr && !force_upd && !(run && (step_up || step_dn))) |=> $stable(ceil_act)); // R9

  AST_BIG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && wdata > ceil_act && !run) |=> $stable(count_o)); // R11

  AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (rst)
    force_upd |=> upd_evt_o); // R10
endmodule

bind qenc_timer qt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .preload(prel_q), .mode(mode_q),
  .a_edge(a_edge), .b_edge(b_edge), .step_up(step_up), .step_dn(step_dn),
  .cnt_wr(cnt_wr), .ceil_wr(ceil_wr), .force_upd(force_upd), .wdata(bus_wdata),
  .ceil_act(ceil_act), .count_o(count_o), .dir_o(dir_o), .upd_evt_o(upd_evt_o)
);

// File: tb/qenc_timer_test.sv
module qenc_timer_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic pa = 1'b0, pb = 1'b0;
  logic [W-1:0] count_o;
  logic dir_o, upd_evt_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [W-1:0] val;
    string       tag;
  } exp_t;
  exp_t sq[$];
  event chk_ev;

  always #5 clk = ~clk;

  qenc_timer uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phase_a(pa), .phase_b(pb), .count_o(count_o), .dir_o(dir_o),
    .upd_evt_o(upd_evt_o)
  );

  // monitor: kind 0 count, 1 direction, 2 update pulse, 3 read data
  initial begin
    forever begin
      @(chk_ev);
      while (sq.size() > 0) begin
        exp_t it;
        logic [W-1:0] got;
        it = sq.pop_front();
        case (it.kind)
          0: got = count_o;
          1: got = W'(dir_o);
          2: got = W'(upd_evt_o);
          default: got = bus_rdata;
        endcase
        total++;
        if (got !== it.val) begin
          bad++;
          $display("FAIL %s kind=%0d got=%0h exp=%0h", it.tag, it.kind, got, it.val);
        end
      end
    end
  end

  task automatic expect_it(input int kind, input logic [W-1:0] v, input string tag);
    exp_t it;
    it.kind = kind; it.val = v; it.tag = tag;
    sq.push_back(it);
    -> chk_ev;
    #0;
  endtask

  task automatic bwr(input int a, input logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input int a, input logic [W-1:0] e, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    expect_it(3, e, tag);
  endtask

  task automatic phs(input logic a, input logic b);
    pa = a; pb = b;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_it(0, 0, "R1 count");
    expect_it(1, 0, "R1 dir");
    expect_it(2, 0, "R1 upd");
    brd(3, 16'hFFFF, "R1 ceiling");
    brd(0, 0, "R1 ctrl");

    // timer mode
    bwr(3, 9);
    bwr(0, 1);
    repeat (5) @(negedge clk);
    bwr(0, 0);
    expect_it(0, 6, "R2 timer count");
    bwr(0, 1);
    repeat (5) @(negedge clk);
    bwr(0, 0);
    expect_it(0, 2, "R8 timer wrap");

    // x4 mode
    bwr(1, 3);
    bwr(2, 0);
    bwr(0, 1);
    pa = 1'b1;
    repeat (2) @(negedge clk);
    expect_it(0, 0, "R12 not yet");
    @(negedge clk);
    expect_it(0, 1, "R12 third edge");
    phs(1, 1); phs(0, 1); phs(0, 0);
    expect_it(0, 4, "R5 forward");
    expect_it(1, 0, "R7 up dir");
    phs(0, 1); phs(1, 1);
    expect_it(0, 2, "R5 reverse");
    expect_it(1, 1, "R7 down dir");
    brd(0, 3, "R7 ctrl dir bit");
    phs(0, 0);
    expect_it(0, 2, "R5 both change");
    phs(0, 1); phs(1, 1); phs(1, 0);
    expect_it(0, 9, "R8 down wrap");
    expect_it(2, 1, "R8 wrap pulse");
    phs(1, 1);
    expect_it(0, 0, "R8 up wrap");

    // stopped
    bwr(0, 0);
    phs(0, 1); phs(0, 0);
    expect_it(0, 0, "R6 frozen");
    bwr(0, 1);
    repeat (4) @(negedge clk);
    expect_it(0, 0, "R6 edges lost");

    // x2 on A
    bwr(1, 1);
    phs(1, 0);
    expect_it(0, 1, "R3 A rise");
    phs(1, 1);
    expect_it(0, 1, "R3 B ignored");
    phs(0, 1); phs(0, 0);
    expect_it(0, 2, "R3 forward");
    phs(0, 1); phs(1, 1);
    expect_it(0, 1, "R3 reverse");
    expect_it(1, 1, "R3 dir down");

    // x2 on B
    bwr(1, 2);
    phs(0, 1);
    expect_it(0, 1, "R4 A ignored");
    phs(0, 0); phs(1, 0); phs(1, 1);
    expect_it(0, 3, "R4 forward");

    // count writes
    bwr(2, 5);
    expect_it(0, 5, "R11 write ok");
    bwr(2, 10);
    expect_it(0, 5, "R11 write too big");

    // preload
    bwr(0, 5);
    bwr(3, 4);
    brd(3, 4, "R9 shadow read");
    bwr(2, 8);
    expect_it(0, 8, "R9 old ceiling active");
    bwr(4, 1);
    expect_it(2, 1, "R10 forced pulse");
    @(negedge clk);
    expect_it(2, 0, "R10 pulse one cycle");
    bwr(2, 6);
    expect_it(0, 8, "R10 new ceiling rejects");
    bwr(2, 4);
    expect_it(0, 4, "R10 new ceiling accepts");

    // immediate ceiling
    bwr(0, 1);
    bwr(3, 2);
    bwr(2, 3);
    expect_it(0, 4, "R9 immediate rejects");
    bwr(2, 2);
    expect_it(0, 2, "R9 immediate accepts");

    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule